// File: doc/BRIEF.md
# Lockable Watchdog Timer with Early-Warning Interrupt

This block is a memory-mapped watchdog. A 32-bit count runs downward at the rate of a slow timebase, 32768 steps per second, so a reload of N seconds is N × 32768. The timebase reaches the block as a one-cycle `tick` strobe in the bus clock domain. Software writes two 32-bit reload values as pairs of 16-bit halves. The expiry reload sets where the count starts. The early-warning threshold sets the count at which a maskable interrupt fires, before the count reaches zero and the block requests a system reset.

All configuration is protected by a key register. Only while that register holds the unlock key do writes to the other registers take effect. A new reload passes to the counter through a short handshake paced by the slow timebase, and a busy flag is visible for as long as it is in flight. Rewriting the reload registers while the counter runs restarts the count, and this is the keep-alive kick. Event flags are sticky, can be read raw, and are cleared by writing ones.

Top module: `lkwd_top`

## Requirements
- R1: After reset every register reads 0, the block is locked, the count is 0, the busy flag is 0, and `irq` and `rst_req` are low.
- R2: Writing 0xE551 to offset 0x20 unlocks the block, and writing any other value locks it. Bit 0 of a read at 0x20 is 1 exactly while the block is unlocked.
- R3: While the block is locked, writes to every offset except 0x20 are ignored. Reads work at any time.
- R4: The expiry reload is {0x04 high half, 0x00 low half} and the threshold is {0x30 high half, 0x2C low half}. The live count reads back as {0x1C high, 0x18 low}.
- R5: An unlocked write to any reload offset sets status bit 4 at offset 0x10. On the second tick after the last such write the counter takes both reload values and bit 4 returns to 0.
- R6: With control (0x08) bit 1 set, the count falls by one on each tick and stays at 0 once it gets there. With bit 1 clear the count holds.
- R7: When a tick steps the count onto the threshold while control bit 0 is set, status bit 0 is set. `irq` follows status bit 0 one cycle later unless mask (0x14) bit 0 is 1, and status bit 0 is set even while masked.
- R8: When a tick steps the count to 0 while control bit 3 is set, status bit 3 is set and `rst_req` rises one cycle later. Both stay high until cleared. If control bits 0 and 3 are clear, no event is recorded.
- R9: Writing 1 to bit 0 or bit 3 of offset 0x0C clears the matching status bit, and the output that depends on it falls one cycle later.
- R10: Reloading while the counter runs restarts the count from the reload value, which postpones expiry.
- R11: Control bits 0 to 3, including the mode bit 2, read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe per slow timebase step |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered one cycle after the address |
| irq | output | 1 | Early-warning interrupt, level |
| rst_req | output | 1 | Expiry reset request, level |

## Verification
The assertions assume that `tick` and `bus_wr` are single-cycle pulses sampled at the rising edge, and that `bus_addr` and `bus_wdata` are stable for the edge of a write. They also assume that reset is held long enough to clear every register. The bench changes all inputs on the falling edge and separates tick pulses with idle cycles. It never issues a write in the same cycle as a tick, so each reload handshake and each count step falls at a known edge. The expected counts come from the reload value minus the number of ticks issued, with a floor at zero.

// File: rtl/lkwd_pkg.sv
package lkwd_pkg;
  localparam int ADDR_W = 6;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_TMO_LO  = 6'h00;
  localparam addr_t A_TMO_HI  = 6'h04;
  localparam addr_t A_CTRL    = 6'h08;
  localparam addr_t A_CLR     = 6'h0C;
  localparam addr_t A_STAT    = 6'h10;
  localparam addr_t A_MASK    = 6'h14;
  localparam addr_t A_CNT_LO  = 6'h18;
  localparam addr_t A_CNT_HI  = 6'h1C;
  localparam addr_t A_KEY     = 6'h20;
  localparam addr_t A_THR_LO  = 6'h2C;
  localparam addr_t A_THR_HI  = 6'h30;

  localparam int C_IRQ_EN = 0;
  localparam int C_RUN    = 1;
  localparam int C_MODE   = 2;
  localparam int C_RST_EN = 3;

  localparam int S_WARN = 0;
  localparam int S_EXP  = 3;
  localparam int S_BUSY = 4;
endpackage

// File: rtl/lkwd_regs.sv
module lkwd_regs
  import lkwd_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter logic [HALF_W-1:0] UNLOCK_KEY = 16'hE551,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  addr_t             bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              st_warn,
  input  logic              st_exp,
  input  logic              ld_busy,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              en_irq,
  output logic              en_run,
  output logic              en_rst,
  output logic              warn_masked,
  output logic [CNT_W-1:0]  tmo_val,
  output logic [CNT_W-1:0]  thr_val,
  output logic              ld_start,
  output logic              clr_warn,
  output logic              clr_exp
);
  logic [HALF_W-1:0] key_q, tmo_lo, tmo_hi, thr_lo, thr_hi, rd_nxt;
  logic [3:0]        ctrl_q;
  logic              mask_q, open_q, wr_ok;

  assign open_q  = (key_q == UNLOCK_KEY);
  assign wr_ok   = bus_wr && open_q;
  assign tmo_val = {tmo_hi, tmo_lo};
  assign thr_val = {thr_hi, thr_lo};
  assign en_irq  = ctrl_q[C_IRQ_EN];
  assign en_run  = ctrl_q[C_RUN];
  assign en_rst  = ctrl_q[C_RST_EN];
  assign warn_masked = mask_q;

  assign ld_start = wr_ok && (bus_addr == A_TMO_LO || bus_addr == A_TMO_HI ||
                              bus_addr == A_THR_LO || bus_addr == A_THR_HI);
  assign clr_warn = wr_ok && (bus_addr == A_CLR) && bus_wdata[S_WARN];
  assign clr_exp  = wr_ok && (bus_addr == A_CLR) && bus_wdata[S_EXP];

  always_comb begin
    rd_nxt = '0;
    case (bus_addr)
      A_TMO_LO: rd_nxt = tmo_lo;
      A_TMO_HI: rd_nxt = tmo_hi;
      A_THR_LO: rd_nxt = thr_lo;
      A_THR_HI: rd_nxt = thr_hi;
      A_CTRL:   rd_nxt[3:0] = ctrl_q;
      A_MASK:   rd_nxt[0] = mask_q;
      A_CNT_LO: rd_nxt = cnt_val[HALF_W-1:0];
      A_CNT_HI: rd_nxt = cnt_val[CNT_W-1:HALF_W];
      A_KEY:    rd_nxt[0] = open_q;
      A_STAT: begin
        rd_nxt[S_WARN] = st_warn;
        rd_nxt[S_EXP]  = st_exp;
        rd_nxt[S_BUSY] = ld_busy;
      end
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q     <= '0;
      tmo_lo    <= '0;
      tmo_hi    <= '0;
      thr_lo    <= '0;
      thr_hi    <= '0;
      ctrl_q    <= '0;
      mask_q    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_nxt;
      if (bus_wr && bus_addr == A_KEY) key_q <= bus_wdata;
      if (wr_ok) begin
        case (bus_addr)
          A_TMO_LO: tmo_lo <= bus_wdata;
          A_TMO_HI: tmo_hi <= bus_wdata;
          A_THR_LO: thr_lo <= bus_wdata;
          A_THR_HI: thr_hi <= bus_wdata;
          A_CTRL:   ctrl_q <= bus_wdata[3:0];
          A_MASK:   mask_q <= bus_wdata[0];
          default:  ;
        endcase
      end
    end
  end

  p_locked_ctrl_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !open_q && bus_addr == A_CTRL) |=> $stable(ctrl_q));
  p_locked_tmo_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !open_q) |=> ($stable(tmo_val) && $stable(thr_val)));
  p_key_opens_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_KEY && bus_wdata == UNLOCK_KEY) |=> open_q);
endmodule

// File: rtl/lkwd_loader.sv
module lkwd_loader #(
  parameter int LOAD_TICKS = 2,
  localparam int PH_W = $clog2(LOAD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  output logic busy,
  output logic go
);
  logic [PH_W-1:0] phase;

  assign go = busy && tick && !start && (phase == PH_W'(LOAD_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      phase <= '0;
    end else if (go) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (busy && tick) begin
      phase <= phase + PH_W'(1);
    end
  end

  p_start_sets_busy_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  p_go_ends_busy_r5: assert property (@(posedge clk) disable iff (rst)
    go |=> !busy);
endmodule

// File: rtl/lkwd_counter.sv
module lkwd_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             irq_en,
  input  logic             rst_en,
  input  logic             go,
  input  logic [CNT_W-1:0] tmo_val,
  input  logic [CNT_W-1:0] thr_val,
  input  logic             clr_warn,
  input  logic             clr_exp,
  output logic [CNT_W-1:0] count,
  output logic             st_warn,
  output logic             st_exp
);
  logic             step;
  logic [CNT_W-1:0] nxt;

  assign step = run && tick && !go && (count != '0);
  assign nxt  = count - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      st_warn <= 1'b0;
      st_exp  <= 1'b0;
    end else begin
      if (go)        count <= tmo_val;
      else if (step) count <= nxt;

      if (step && irq_en && nxt == thr_val) st_warn <= 1'b1;
      else if (clr_warn)                    st_warn <= 1'b0;

      if (step && rst_en && nxt == '0) st_exp <= 1'b1;
      else if (clr_exp)                st_exp <= 1'b0;
    end
  end

  p_hold_when_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!run && !go) |=> $stable(count));
  p_floor_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !go) |=> (count == '0));
  p_warn_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (st_warn && !clr_warn) |=> st_warn);
  p_exp_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (st_exp && !clr_exp) |=> st_exp);
endmodule

// File: rtl/lkwd_top.sv
module lkwd_top
  import lkwd_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int LOAD_TICKS = 2,
  parameter logic [HALF_W-1:0] UNLOCK_KEY = 16'hE551,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  logic [CNT_W-1:0] count, tmo_val, thr_val;
  logic st_warn, st_exp, ld_busy, ld_go, ld_start;
  logic en_irq, en_run, en_rst, warn_masked, clr_warn, clr_exp;

  lkwd_regs #(.HALF_W(HALF_W), .UNLOCK_KEY(UNLOCK_KEY)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt_val(count), .st_warn(st_warn),
    .st_exp(st_exp), .ld_busy(ld_busy), .bus_rdata(bus_rdata),
    .en_irq(en_irq), .en_run(en_run), .en_rst(en_rst),
    .warn_masked(warn_masked), .tmo_val(tmo_val), .thr_val(thr_val),
    .ld_start(ld_start), .clr_warn(clr_warn), .clr_exp(clr_exp)
  );

  lkwd_loader #(.LOAD_TICKS(LOAD_TICKS)) u_loader (
    .clk(clk), .rst(rst), .tick(tick), .start(ld_start),
    .busy(ld_busy), .go(ld_go)
  );

  lkwd_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .tick(tick), .run(en_run), .irq_en(en_irq),
    .rst_en(en_rst), .go(ld_go), .tmo_val(tmo_val), .thr_val(thr_val),
    .clr_warn(clr_warn), .clr_exp(clr_exp), .count(count),
    .st_warn(st_warn), .st_exp(st_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      irq     <= st_warn && !warn_masked;
      rst_req <= st_exp;
    end
  end

  p_mask_blocks_irq_r7: assert property (@(posedge clk) disable iff (rst)
    warn_masked |=> !irq);
  p_exp_drives_req_r8: assert property (@(posedge clk) disable iff (rst)
    st_exp |=> rst_req);
endmodule

// File: tb/tb_lkwd_top.sv
`timescale 1ns/1ps
module tb_lkwd_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, rst_req;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lkwd_top dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic rd_count(output logic [31:0] c);
    logic [15:0] hi, lo;
    rd(6'h1C, hi);
    rd(6'h18, lo);
    c = {hi, lo};
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic load(input logic [31:0] t, input logic [31:0] p);
    wr(6'h04, t[31:16]);
    wr(6'h00, t[15:0]);
    wr(6'h30, p[31:16]);
    wr(6'h2C, p[15:0]);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [31:0] c;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(6'h08, v); check("R1 ctrl", v, 0);
    rd(6'h10, v); check("R1 status", v, 0);
    rd(6'h20, v); check("R1 locked", v, 0);
    rd_count(c);  check("R1 count", c, 0);
    check("R1 irq", irq, 0);
    check("R1 rst_req", rst_req, 0);

    // R3 locked writes ignored
    wr(6'h08, 16'h000F); rd(6'h08, v); check("R3 ctrl locked", v, 0);
    wr(6'h00, 16'h0005); rd(6'h00, v); check("R3 reload locked", v, 0);
    rd(6'h10, v); check("R3 no busy when locked", v, 0);

    // R2 key handling
    wr(6'h20, 16'hE551); rd(6'h20, v); check("R2 unlock", v, 1);
    wr(6'h20, 16'h1234); rd(6'h20, v); check("R2 wrong key locks", v, 0);
    wr(6'h08, 16'h0002); rd(6'h08, v); check("R2 ctrl ignored after relock", v, 0);
    wr(6'h20, 16'hE551);

    // R11 ctrl readback sweep
    for (int k = 0; k < 16; k++) begin
      wr(6'h08, 16'(k)); rd(6'h08, v); check("R11 ctrl readback", v, 32'(k));
    end
    wr(6'h08, 16'h0000);

    // R4 / R5 halves and busy handshake
    load(32'h0001_0003, 32'h0002_0007);
    rd(6'h04, v); check("R4 tmo hi", v, 16'h0001);
    rd(6'h00, v); check("R4 tmo lo", v, 16'h0003);
    rd(6'h30, v); check("R4 thr hi", v, 16'h0002);
    rd(6'h2C, v); check("R4 thr lo", v, 16'h0007);
    rd(6'h10, v); check("R5 busy set", v, 16'h0010);
    tk(1);
    rd(6'h10, v); check("R5 busy after one tick", v, 16'h0010);
    rd_count(c);  check("R5 count not yet loaded", c, 0);
    tk(1);
    rd(6'h10, v); check("R5 busy cleared", v, 0);
    rd_count(c);  check("R4 count loaded", c, 32'h0001_0003);

    // R6 count sweep with floor
    wr(6'h08, 16'h0002);
    for (int l = 3; l <= 8; l++) begin
      load(32'(l), 32'h0);
      tk(2);
      rd_count(c); check("R6 start value", c, 32'(l));
      for (int k = 1; k <= l + 2; k++) begin
        tk(1);
        rd_count(c);
        check("R6 step", c, (k <= l) ? 32'(l - k) : 32'h0);
      end
    end
    rd(6'h10, v); check("R8 no events when disabled", v, 0);
    check("R8 no rst_req when disabled", rst_req, 0);
    wr(6'h08, 16'h0000);
    load(32'd10, 32'h0);
    tk(2);
    tk(3);
    rd_count(c); check("R6 hold when stopped", c, 10);

    // R7 early warning, unmasked
    wr(6'h14, 16'h0000);
    wr(6'h08, 16'h0003);
    load(32'd10, 32'd4);
    tk(2);
    tk(5);
    rd_count(c); check("R7 count before threshold", c, 5);
    check("R7 irq low before threshold", irq, 0);
    tk(1);
    rd(6'h10, v); check("R7 status warn", v, 16'h0001);
    check("R7 irq high", irq, 1);
    wr(6'h0C, 16'h0001);
    rd(6'h10, v); check("R9 warn cleared", v, 0);
    check("R9 irq low after clear", irq, 0);

    // R7 masked
    wr(6'h14, 16'h0001);
    load(32'd10, 32'd4);
    tk(2);
    tk(6);
    rd(6'h10, v); check("R7 masked status set", v, 16'h0001);
    check("R7 masked irq low", irq, 0);
    wr(6'h14, 16'h0000);
    rd(6'h10, v);
    check("R7 unmask raises irq", irq, 1);
    wr(6'h0C, 16'h0001);

    // R8 expiry
    wr(6'h08, 16'h000B);
    load(32'd6, 32'd3);
    tk(2);
    tk(5);
    rd_count(c); check("R8 count one left", c, 1);
    check("R8 rst_req low before expiry", rst_req, 0);
    tk(1);
    rd(6'h10, v); check("R8 status exp", v, 16'h0009);
    check("R8 rst_req high", rst_req, 1);
    tk(3);
    rd_count(c); check("R8 count stays zero", c, 0);
    check("R8 rst_req sticky", rst_req, 1);
    wr(6'h0C, 16'h0009);
    rd(6'h10, v); check("R9 both cleared", v, 0);
    check("R9 rst_req low", rst_req, 0);
    tk(2);
    rd(6'h10, v); check("R8 no retrigger at zero", v, 0);

    // R10 keep-alive reload
    wr(6'h08, 16'h000A);
    load(32'd8, 32'h0);
    tk(2);
    tk(5);
    rd_count(c); check("R10 before kick", c, 3);
    load(32'd8, 32'h0);
    tk(2);
    rd_count(c); check("R10 after kick", c, 8);
    tk(5);
    rd_count(c); check("R10 counting resumed", c, 3);
    check("R10 no expiry", rst_req, 0);

    // R2 relock stops control writes
    wr(6'h20, 16'h0000);
    wr(6'h08, 16'h0000);
    rd(6'h08, v); check("R2 relocked ctrl kept", v, 16'h000A);
    rd(6'h20, v); check("R2 relocked", v, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule